// File: doc/BRIEF.md
# Quadrature DAC output formatter

This block sits between a quadrature waveform source and a pair of digital-to-analog converters. On each clock it can take a new pair of signed samples, one for the sine channel and one for the cosine channel, and present them to the converters. A format input chooses the number code for the converters. With the format input low, words leave as two's complement. With it high, they leave as offset binary. A mode input chooses how the words leave the block: as two full-width parallel words, or as two single-bit streams that run side by side.

In parallel mode every offered pair is captured on the next clock edge and shown on the parallel buses, and the strobe marks each new pair. In serial mode a word counter frames 16-clock words. A new pair is taken only at a word boundary: on the clock where serial mode is entered, or on the clock that carries the last bit of a word. A pair offered at any other time is ignored. If no pair is offered at a boundary, the word held from before is sent again. A one-clock sync marks the first bit of each serial word, and the strobe marks its last bit. Each channel has its own output enable, which releases that channel's parallel bus and serial line to high impedance.

Top module: `qdac_formatter`

## Requirements
- R1: While reset is held and on the first cycle after its release, both parallel buses read 0x0000, both serial lines read 0, and word_sync and dac_strobe are low.
- R2: In parallel mode (ser_mode=0), a pair offered with smp_valid=1 appears on sin_par/cos_par on the cycle after it is offered, and dac_strobe is high for that one cycle.
- R3: In parallel mode, a cycle with smp_valid=0 leaves both parallel words unchanged, and dac_strobe is low on the following cycle.
- R4: fmt_offset=0 passes each sample unchanged (two's complement). fmt_offset=1 inverts bit 15 only (offset binary), so 0x8000 becomes 0x0000 and 0x7FFF becomes 0xFFFF. The format is sampled on the same edge that captures the pair.
- R5: In serial mode, sin_ser and cos_ser carry the captured words most significant bit first, one bit per clock for 16 clocks. The first bit appears on the cycle after serial mode is entered.
- R6: word_sync is high for exactly one clock, on the cycle that carries bit 15 of each serial word, and it is low at all other times.
- R7: In serial mode, dac_strobe is high on the cycle that carries bit 0. The pair offered in that cycle becomes the next word, and its bit 15 follows on the very next cycle with no gap.
- R8: In serial mode, pairs and format values offered on any cycle other than a word boundary are ignored, and the word being shifted is not altered.
- R9: In serial mode, if smp_valid is low at a word boundary, the previously held word is sent again.
- R10: oe_sin=0 drives sin_par and sin_ser to high impedance, and oe_cos=0 does the same for cos_par and cos_ser. Each enable affects only its own channel.
- R11: In serial mode, the parallel buses show the word that is currently being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which also sets the word rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A new sample pair is offered this cycle |
| smp_sin | input | 16 | Sine sample, two's complement |
| smp_cos | input | 16 | Cosine sample, two's complement |
| fmt_offset | input | 1 | 1 selects offset binary, 0 selects two's complement |
| ser_mode | input | 1 | 1 selects serial output, 0 selects parallel output |
| oe_sin | input | 1 | Output enable for the sine channel |
| oe_cos | input | 1 | Output enable for the cosine channel |
| sin_par | output | 16 | Sine word, parallel |
| cos_par | output | 16 | Cosine word, parallel |
| sin_ser | output | 1 | Sine bit stream, MSB first |
| cos_ser | output | 1 | Cosine bit stream, MSB first |
| word_sync | output | 1 | First bit of a serial word |
| dac_strobe | output | 1 | New parallel pair, or last bit of a serial word |

## Verification
Some properties are checked on every clock. A sync always follows either entry into serial mode or the strobe of the previous word, and a sync never lasts two cycles. The shift register moves exactly one place per bit. The held words stay frozen between word boundaries. A parallel capture always raises the strobe, and offset format always flips the sign bit. Other behaviour can only be shown by the bench's scenarios. These are the exact bit order of whole words, back-to-back framing across words with and without new data, junk data and format changes offered mid-word, the exact conversion of the extreme codes, and the high-impedance release of one channel while the other keeps driving.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } num_fmt_e;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } out_mode_e;

  localparam int NCH = 2;

endpackage

// File: rtl/qdac_fmt_conv.sv
module qdac_fmt_conv
  import qdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] smp_i,
  input  num_fmt_e     fmt_i,
  output logic [W-1:0] word_o
);

  always_comb begin
    word_o = smp_i;
    if (fmt_i == FMT_OFFSET) begin
      word_o[W-1] = ~smp_i[W-1];
    end
  end

endmodule

// File: rtl/qdac_word_hold.sv
module qdac_word_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d;
  logic [W-1:0] q_q;

  always_comb begin
    q_d = q_q;
    if (we_i) begin
      q_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (we_i) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/qdac_ser_ctrl.sv
module qdac_ser_ctrl
  import qdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  out_mode_e mode_i,
  output logic      active_o,
  output logic      boundary_o,
  output logic      shift_o,
  output logic      sync_o,
  output logic      strobe_o
);

  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             at_last;
  logic             ser_sel;

  assign ser_sel    = (mode_i == MODE_SER);
  assign at_last    = (cnt_q == LAST);
  assign boundary_o = ser_sel && (!act_q || at_last);
  assign shift_o    = ser_sel && act_q && !at_last;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (!ser_sel) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (boundary_o) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = act_q;
  assign sync_o   = act_q && (cnt_q == '0);
  assign strobe_o = act_q && at_last;

  // R5 / R6: entering serial mode opens a word on the next cycle
  p_entry_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && !act_q) |=> sync_o);

  // R7: the last bit of a word is followed at once by the next word's sync
  p_strobe_then_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && ser_sel) |=> sync_o);

  // R6: the sync lasts a single clock
  p_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  // R6: every sync is preceded by an entry or by the last bit of a word
  p_sync_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> ($past(strobe_o) || !$past(act_q)));

endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] d_i,
  output logic         bit_o
);

  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  assign sr_en = load_i || shift_i;

  always_comb begin
    sr_d = sr_q;
    if (load_i) begin
      sr_d = d_i;
    end else if (shift_i) begin
      sr_d = {sr_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign bit_o = sr_q[W-1];

  // R5: each shift moves the next lower bit into the output position
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (bit_o == $past(sr_q[W-2])));

endmodule

// File: rtl/qdac_tri_out.sv
module qdac_tri_out #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output wire  [W-1:0] pad_o
);

  assign pad_o = en_i ? d_i : {W{1'bz}};

endmodule

// File: rtl/qdac_formatter.sv
module qdac_formatter
  import qdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_sin,
  input  logic [W-1:0] smp_cos,
  input  logic         fmt_offset,
  input  logic         ser_mode,
  input  logic         oe_sin,
  input  logic         oe_cos,
  output wire  [W-1:0] sin_par,
  output wire  [W-1:0] cos_par,
  output wire          sin_ser,
  output wire          cos_ser,
  output logic         word_sync,
  output logic         dac_strobe
);

  num_fmt_e  fmt_sel;
  out_mode_e mode_sel;

  assign fmt_sel  = num_fmt_e'(fmt_offset);
  assign mode_sel = out_mode_e'(ser_mode);

  logic [W-1:0] raw  [NCH];
  logic [W-1:0] conv [NCH];
  logic [W-1:0] held [NCH];
  logic [W-1:0] load_src [NCH];
  logic         ser_bit [NCH];

  assign raw[0] = smp_sin;
  assign raw[1] = smp_cos;

  logic ser_act, boundary, shift_en, sync_ser, strobe_ser;
  logic hold_we, ser_load;
  logic par_stb_q, par_stb_d;

  qdac_ser_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_sel),
    .active_o   (ser_act),
    .boundary_o (boundary),
    .shift_o    (shift_en),
    .sync_o     (sync_ser),
    .strobe_o   (strobe_ser)
  );

  assign hold_we  = smp_valid && ((mode_sel == MODE_PAR) || boundary);
  assign ser_load = boundary;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      qdac_fmt_conv #(.W(W)) u_conv (
        .smp_i  (raw[ch]),
        .fmt_i  (fmt_sel),
        .word_o (conv[ch])
      );

      qdac_word_hold #(.W(W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (hold_we),
        .d_i   (conv[ch]),
        .q_o   (held[ch])
      );

      assign load_src[ch] = smp_valid ? conv[ch] : held[ch];

      qdac_shift #(.W(W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ser_load),
        .shift_i (shift_en),
        .d_i     (load_src[ch]),
        .bit_o   (ser_bit[ch])
      );
    end
  endgenerate

  always_comb begin
    par_stb_d = (mode_sel == MODE_PAR) && smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_stb_q <= 1'b0;
    end else begin
      par_stb_q <= par_stb_d;
    end
  end

  assign word_sync  = sync_ser;
  assign dac_strobe = ser_act ? strobe_ser : par_stb_q;

  qdac_tri_out #(.W(W)) u_sin_par (.en_i(oe_sin), .d_i(held[0]),    .pad_o(sin_par));
  qdac_tri_out #(.W(W)) u_cos_par (.en_i(oe_cos), .d_i(held[1]),    .pad_o(cos_par));
  qdac_tri_out #(.W(1)) u_sin_ser (.en_i(oe_sin), .d_i(ser_bit[0]), .pad_o(sin_ser));
  qdac_tri_out #(.W(1)) u_cos_ser (.en_i(oe_cos), .d_i(ser_bit[1]), .pad_o(cos_ser));

  // R2: a parallel capture is always marked by the strobe
  p_par_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && smp_valid) |=> dac_strobe);

  // R3: an idle parallel cycle keeps the words and no strobe
  p_par_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && !smp_valid) |=> (!dac_strobe && $stable(held[0]) && $stable(held[1])));

  // R4: offset format flips the sign bit of the captured word
  p_offset_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && smp_valid && fmt_offset) |=> (held[0][W-1] != $past(smp_sin[W-1])));

  // R8: held words never change between serial word boundaries
  p_mid_word_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && ser_act && !boundary) |=> ($stable(held[0]) && $stable(held[1])));

endmodule

// File: tb/qdac_formatter_bench.sv
module qdac_formatter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_sin, smp_cos;
  logic        fmt_offset, ser_mode, oe_sin, oe_cos;
  wire  [15:0] sin_par, cos_par;
  wire         sin_ser, cos_ser;
  logic        word_sync, dac_strobe;

  always #2.5 clk = ~clk;

  qdac_formatter u_qdac_formatter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_sin(smp_sin), .smp_cos(smp_cos), .fmt_offset(fmt_offset),
    .ser_mode(ser_mode), .oe_sin(oe_sin), .oe_cos(oe_cos),
    .sin_par(sin_par), .cos_par(cos_par), .sin_ser(sin_ser), .cos_ser(cos_ser),
    .word_sync(word_sync), .dac_strobe(dac_strobe)
  );

  typedef struct {
    int          tgt;
    logic [15:0] ps, pc;
    logic        stb, syn, ss, cs, chk_ser;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [15:0] hs, hc;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] fmtv(logic [15:0] v, logic f);
    return {v[15] ^ f, v[14:0]};
  endfunction

  task automatic push(int tgt, logic [15:0] ps, logic [15:0] pc, logic stb,
                      logic syn, logic ss, logic cs, logic chk_ser, string req);
    exp_t e;
    e.tgt = tgt; e.ps = ps; e.pc = pc; e.stb = stb; e.syn = syn;
    e.ss = ss; e.cs = cs; e.chk_ser = chk_ser; e.req = req;
    q.push_back(e);
  endtask

  task automatic drive(logic v, logic [15:0] s, logic [15:0] c, logic f, logic sm);
    @(posedge clk);
    #1;
    smp_valid = v; smp_sin = s; smp_cos = c; fmt_offset = f; ser_mode = sm;
  endtask

  // one parallel-mode cycle: expected result lands on the next cycle
  task automatic par(logic v, logic [15:0] s, logic [15:0] c, logic f, string req);
    drive(v, s, c, f, 1'b0);
    if (v) begin
      hs = fmtv(s, f);
      hc = fmtv(c, f);
    end
    push(cyc + 1, hs, hc, v, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  // one serial word: k=0 offers the boundary pair, later cycles offer junk
  task automatic ser_word(logic v, logic [15:0] s, logic [15:0] c, logic f,
                          logic [15:0] junk, string req);
    for (int k = 0; k < 16; k++) begin
      if (k == 0) begin
        drive(v, s, c, f, 1'b1);
        if (v) begin
          hs = fmtv(s, f);
          hc = fmtv(c, f);
        end
      end else begin
        drive(1'b1, junk, ~junk, ~f, 1'b1);
      end
      push(cyc + 1, hs, hc, (k == 15), (k == 0), hs[15-k], hc[15-k], 1'b1, req);
    end
  endtask

  function automatic bit hiz16(logic [15:0] v);
    return (v === 16'hzzzz) || (v === 16'h0000);
  endfunction

  function automatic bit hiz1(logic v);
    return (v === 1'bz) || (v === 1'b0);
  endfunction

  exp_t it;
  bit   ok;
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].tgt < cyc) begin
      it = q.pop_front();
      n_chk++; n_fail++;
      $display("FAIL %s: expectation for cycle %0d missed, actual cycle %0d expected %0d",
               it.req, it.tgt, cyc, it.tgt);
    end
    if (q.size() > 0 && q[0].tgt == cyc) begin
      it = q.pop_front();
      n_chk++;
      ok = 1'b1;
      if (oe_sin) begin
        if (sin_par !== it.ps) ok = 1'b0;
        if (it.chk_ser && sin_ser !== it.ss) ok = 1'b0;
      end else begin
        if (!hiz16(sin_par) || !hiz1(sin_ser)) ok = 1'b0;
      end
      if (oe_cos) begin
        if (cos_par !== it.pc) ok = 1'b0;
        if (it.chk_ser && cos_ser !== it.cs) ok = 1'b0;
      end else begin
        if (!hiz16(cos_par) || !hiz1(cos_ser)) ok = 1'b0;
      end
      if (dac_strobe !== it.stb) ok = 1'b0;
      if (word_sync !== it.syn) ok = 1'b0;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s @%0d: actual sin=%h cos=%h ss=%b cs=%b stb=%b sync=%b oe=%b%b | expected sin=%h cos=%h ss=%b cs=%b stb=%b sync=%b",
                 it.req, cyc, sin_par, cos_par, sin_ser, cos_ser, dac_strobe, word_sync,
                 oe_sin, oe_cos, it.ps, it.pc, it.ss, it.cs, it.stb, it.syn);
      end
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_sin = '0; smp_cos = '0;
    fmt_offset = 1'b0; ser_mode = 1'b0; oe_sin = 1'b1; oe_cos = 1'b1;
    hs = '0; hc = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push(cyc, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 reset state");

    par(1'b1, 16'h1234, 16'hABCD, 1'b0, "R2 parallel capture two's complement");
    par(1'b1, 16'h8000, 16'h7FFF, 1'b1, "R4 offset binary extremes");
    par(1'b0, 16'h5555, 16'h6666, 1'b0, "R3 idle parallel holds");
    par(1'b1, 16'h0001, 16'hFFFF, 1'b0, "R2 second capture");
    par(1'b1, 16'h0001, 16'hFFFF, 1'b1, "R4 offset binary small values");
    par(1'b0, 16'h0000, 16'h0000, 1'b1, "R3 idle after capture");

    // R10: release sine only, then cosine only
    oe_sin = 1'b0;
    par(1'b0, 16'h0, 16'h0, 1'b0, "R10 sine released, cosine driven");
    par(1'b0, 16'h0, 16'h0, 1'b0, "R10 sine released, cosine driven");
    oe_sin = 1'b1; oe_cos = 1'b0;
    par(1'b1, 16'h4321, 16'h1357, 1'b0, "R10 cosine released, sine driven");
    par(1'b0, 16'h0, 16'h0, 1'b0, "R10 cosine released, sine driven");
    oe_cos = 1'b1;
    par(1'b0, 16'h0, 16'h0, 1'b0, "R10 both driven again");

    // serial: entry word, back-to-back word with offset, retransmit
    ser_word(1'b1, 16'hA5C3, 16'h3C5A, 1'b0, 16'hFFFF, "R5 R6 R8 R11 serial entry word");
    ser_word(1'b1, 16'h8001, 16'h7FFE, 1'b1, 16'h0000, "R7 R4 back-to-back offset word");
    ser_word(1'b0, 16'h1111, 16'h2222, 1'b0, 16'h5A5A, "R9 retransmit without new pair");

    par(1'b1, 16'hCAFE, 16'h0BAD, 1'b0, "R2 back to parallel");
    par(1'b0, 16'h0, 16'h0, 1'b0, "R3 idle after serial");

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule